// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one software interrupt request bit for each hart and presents each bit as a 32-bit word on a simple register bus. Software running on any hart raises an interrupt on another hart by writing a one to that hart's word. The interrupt appears on the matching bit of `swi_o`, which is wired to the hart's interrupt input. The bank has no other registers.

A single parameter selects one of two modes. In machine mode the word behaves as an ordinary read/write pending bit: writing a zero clears it, a read returns it, and reset clears every bit. In supervisor mode the word is set-only and always reads zero. A software write of zero does nothing, reset leaves the outputs as they are, and the pending bit can only be retired by a per-hart clear strobe coming from the hart side on `hart_clr`.

Each hart's bit is a two-state machine with the states `SWI_IDLE` and `SWI_PEND`. The transition IDLE→PEND ("raise") is taken on an accepted write of one. The transition PEND→IDLE ("retire") is taken on the mode's clear source, and only when no raise for that hart arrives in the same cycle. In every other case the state holds.

Top module: `swi_bank`

## Requirements
- R1: Hart i owns the 32-bit word at byte offset 4·i. An accepted write with wdata bit 0 = 1 to that word sets `swi_o[i]` at the next rising clock edge and leaves every other hart's bit unchanged.
- R2: Only wdata bit 0 is significant. Bits 31..1 of the write data do not affect the result.
- R3: An access is acted on only when `bus_addr[1:0]` = 2'b00 and `bus_be` = 4'b1111. Any other access leaves the outputs unchanged and reads as zero.
- R4: An offset at or above 4·N_HARTS is undecoded. A write there is ignored, and a read there returns zero.
- R5: In machine mode, an accepted write with wdata bit 0 = 0 clears that hart's bit at the next edge.
- R6: In supervisor mode, an accepted write with wdata bit 0 = 0 has no effect.
- R7: In machine mode, a read returns the hart's pending bit in `bus_rdata[0]` with bits 31..1 zero. `bus_rdata` is registered: it is valid the cycle after the read request and zero in any cycle that follows no accepted read.
- R8: In supervisor mode, `bus_rdata` is always zero.
- R9: In machine mode, reset clears every bit of `swi_o`. In supervisor mode, reset leaves `swi_o` unchanged.
- R10: In supervisor mode, `hart_clr[i]` = 1 clears `swi_o[i]` at the next edge. A software set of the same hart in the same cycle wins, and the bit stays set.
- R11: In machine mode, `hart_clr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the bank |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data, bit 0 used |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| hart_clr | input | N_HARTS | Hart-side clear strobes (supervisor mode) |
| swi_o | output | N_HARTS | Software interrupt per hart |

## Verification
The bench builds two copies with N_HARTS = 4 and ADDR_W = 8, one in machine mode and one in supervisor mode. Both copies share the same bus stimulus, so a single write shows the contrast between the modes: the machine copy clears on a write of zero while the supervisor copy holds. With an 8-bit address, offsets past the four decoded words (word indices 4 to 63) can be reached, which exercises the undecoded range. Each copy has its own clear strobes, so the same-cycle set-versus-clear race can be driven in both modes.

// File: rtl/swi_pkg.sv
package swi_pkg;
    typedef enum logic {
        SWI_IDLE = 1'b0,
        SWI_PEND = 1'b1
    } swi_state_e;

    typedef enum logic {
        SWI_MODE_MACHINE = 1'b0,
        SWI_MODE_SUPER   = 1'b1
    } swi_mode_e;

    localparam int unsigned SWI_DATA_W = 32;
    localparam int unsigned SWI_BE_W   = SWI_DATA_W / 8;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
    parameter int unsigned N_HARTS = 4,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned IDX_W  = ADDR_W - 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [swi_pkg::SWI_BE_W-1:0] be,
    input  logic                      wbit,
    output logic [N_HARTS-1:0]        set_v,
    output logic [N_HARTS-1:0]        clr_v,
    output logic                      rd_hit,
    output logic [IDX_W-1:0]          rd_idx
);
    logic [IDX_W-1:0] word_idx;
    logic             in_range;
    logic             legal;

    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        in_range = 32'(word_idx) < N_HARTS;
        legal    = sel && (be == '1) && (addr[1:0] == 2'b00) && in_range;
        rd_hit   = legal && !wr;
        rd_idx   = word_idx;
    end

    for (genvar i = 0; i < N_HARTS; i++) begin : g_strobe
        assign set_v[i] = legal && wr && (word_idx == IDX_W'(i)) && wbit;
        assign clr_v[i] = legal && wr && (word_idx == IDX_W'(i)) && !wbit;
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_v | clr_v)); // R1
    AST_UNDECODED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && 32'(addr[ADDR_W-1:2]) >= N_HARTS) |-> (set_v == '0 && clr_v == '0 && !rd_hit)); // R4
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (be != '1 || addr[1:0] != 2'b00)) |-> (set_v == '0 && clr_v == '0 && !rd_hit)); // R3
endmodule

// File: rtl/swi_hart_cell.sv
module swi_hart_cell #(
    parameter swi_pkg::swi_mode_e MODE = swi_pkg::SWI_MODE_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hart_clr,
    output logic pend_o
);
    import swi_pkg::*;

    swi_state_e st_q, st_d;
    logic       clr_req;

    // next-state: raise on set, retire on the mode's clear source; set wins
    always_comb begin
        clr_req = (MODE == SWI_MODE_MACHINE) ? sw_clr : hart_clr;
        st_d    = st_q;
        unique case (st_q)
            SWI_IDLE: if (sw_set) st_d = SWI_PEND;
            SWI_PEND: if (!sw_set && clr_req) st_d = SWI_IDLE;
            default:  st_d = SWI_IDLE;
        endcase
    end

    // state register: resettable only in machine mode
    if (MODE == SWI_MODE_MACHINE) begin : g_rst_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= SWI_IDLE;
            else        st_q <= st_d;
        end
    end else begin : g_keep_reg
        always_ff @(posedge clk) begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        pend_o = (st_q == SWI_PEND);
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> pend_o); // R1
    AST_SUPER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == SWI_MODE_SUPER && hart_clr && !sw_set) |=> !pend_o); // R10
    AST_SUPER_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == SWI_MODE_SUPER && sw_clr && !hart_clr) |=> pend_o == $past(pend_o)); // R6
    AST_MACH_NO_HCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == SWI_MODE_MACHINE && !sw_set && !sw_clr) |=> pend_o == $past(pend_o)); // R11
    AST_MACH_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == SWI_MODE_MACHINE && sw_clr) |=> !pend_o); // R5
endmodule

// File: rtl/swi_readback.sv
module swi_readback #(
    parameter swi_pkg::swi_mode_e MODE = swi_pkg::SWI_MODE_MACHINE,
    parameter int unsigned N_HARTS = 4,
    parameter int unsigned IDX_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_hit,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [N_HARTS-1:0]            pend_v,
    output logic [swi_pkg::SWI_DATA_W-1:0] rdata
);
    import swi_pkg::*;

    logic sel_bit;

    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < N_HARTS; i++) begin
            if (rd_idx == IDX_W'(i)) sel_bit = pend_v[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_hit && MODE == SWI_MODE_MACHINE)
            rdata <= {{(SWI_DATA_W-1){1'b0}}, sel_bit};
        else
            rdata <= '0;
    end

    AST_SUPER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == SWI_MODE_SUPER) |-> rdata == '0); // R8
    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[SWI_DATA_W-1:1] == '0); // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> rdata == '0); // R7
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
    parameter swi_pkg::swi_mode_e MODE = swi_pkg::SWI_MODE_MACHINE,
    parameter int unsigned N_HARTS = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_HARTS-1:0] hart_clr,
    output logic [N_HARTS-1:0] swi_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [N_HARTS-1:0] set_v;
    logic [N_HARTS-1:0] clr_v;
    logic               rd_hit;
    logic [IDX_W-1:0]   rd_idx;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:1];

    swi_decode #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
        .wbit(bus_wdata[0]),
        .set_v(set_v), .clr_v(clr_v), .rd_hit(rd_hit), .rd_idx(rd_idx)
    );

    for (genvar i = 0; i < N_HARTS; i++) begin : g_hart
        swi_hart_cell #(.MODE(MODE)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .sw_set(set_v[i]), .sw_clr(clr_v[i]), .hart_clr(hart_clr[i]),
            .pend_o(swi_o[i])
        );
    end

    swi_readback #(.MODE(MODE), .N_HARTS(N_HARTS), .IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_hit(rd_hit), .rd_idx(rd_idx), .pend_v(swi_o),
        .rdata(bus_rdata)
    );
endmodule

// File: tb/swi_bank_tb.sv
module swi_bank_tb_top;
    import swi_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  m_clr = '0;
    logic [3:0]  s_clr = '0;
    logic [31:0] m_rdata, s_rdata;
    logic [3:0]  m_irq, s_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk; // 50 MHz

    swi_bank #(.MODE(SWI_MODE_MACHINE), .N_HARTS(4), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(m_rdata), .hart_clr(m_clr), .swi_o(m_irq)
    );

    swi_bank #(.MODE(SWI_MODE_SUPER), .N_HARTS(4), .ADDR_W(8)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(s_rdata), .hart_clr(s_clr), .swi_o(s_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [3:0]  exp_m;
        logic [3:0]  exp_s;
        logic [31:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 4'hF, 32'h0000_0001, 4'b0001, 4'b0001, 32'h0, 4'd1},  // R1 set hart0
        '{1'b1, 8'h0C, 4'hF, 32'hFFFF_FFFF, 4'b1001, 4'b1001, 32'h0, 4'd2},  // R2 high bits ignored
        '{1'b0, 8'h00, 4'hF, 32'h0,         4'b1001, 4'b1001, 32'h1, 4'd7},  // R7 read pending
        '{1'b0, 8'h04, 4'hF, 32'h0,         4'b1001, 4'b1001, 32'h0, 4'd7},  // R7 read idle hart
        '{1'b1, 8'h00, 4'hF, 32'hFFFF_FFFE, 4'b1000, 4'b1001, 32'h0, 4'd5},  // R5 / R6 write zero
        '{1'b1, 8'h05, 4'hF, 32'h0000_0001, 4'b1000, 4'b1001, 32'h0, 4'd3},  // R3 misaligned
        '{1'b1, 8'h04, 4'h3, 32'h0000_0001, 4'b1000, 4'b1001, 32'h0, 4'd3},  // R3 partial enables
        '{1'b1, 8'h10, 4'hF, 32'h0000_0001, 4'b1000, 4'b1001, 32'h0, 4'd4},  // R4 undecoded write
        '{1'b0, 8'h10, 4'hF, 32'h0,         4'b1000, 4'b1001, 32'h0, 4'd4},  // R4 undecoded read
        '{1'b0, 8'h0C, 4'hF, 32'h0,         4'b1000, 4'b1001, 32'h1, 4'd7},  // R7 read hart3
        '{1'b1, 8'h0C, 4'hF, 32'h0,         4'b0000, 4'b1001, 32'h0, 4'd6},  // R6 / R5 write zero
        '{1'b1, 8'h08, 4'hF, 32'h0000_0001, 4'b0100, 4'b1101, 32'h0, 4'd1},  // R1 set hart2
        '{1'b0, 8'h0A, 4'hF, 32'h0,         4'b0100, 4'b1101, 32'h0, 4'd3}   // R3 misaligned read
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset machine irq", {28'h0, m_irq}, 32'h0);
        check("R7", "reset machine rdata", m_rdata, 32'h0);
        rst_n = 1'b1;
        // bring supervisor copy to a known state through its hart-side clear
        s_clr = 4'hF;
        @(negedge clk);
        s_clr = 4'h0;
        check("R10", "supervisor cleared", {28'h0, s_irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            access(VECS[k].wr, VECS[k].addr, VECS[k].be, VECS[k].wdata);
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d machine irq", k),
                  {28'h0, m_irq}, {28'h0, VECS[k].exp_m});
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d supervisor irq", k),
                  {28'h0, s_irq}, {28'h0, VECS[k].exp_s});
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d machine rdata", k),
                  m_rdata, VECS[k].exp_rd);
            check("R8", $sformatf("vec %0d supervisor rdata", k), s_rdata, 32'h0);
        end

        // R11: hart-side clear ignored in machine mode
        m_clr = 4'hF;
        @(negedge clk);
        m_clr = 4'h0;
        check("R11", "machine ignores hart_clr", {28'h0, m_irq}, 32'h4);

        // R10: hart-side clear retires one supervisor bit
        s_clr = 4'b0001;
        @(negedge clk);
        s_clr = 4'h0;
        check("R10", "supervisor hart_clr", {28'h0, s_irq}, 32'hC);

        // R10: set and clear of hart3 in the same cycle, set wins
        s_clr = 4'b1000;
        access(1'b1, 8'h0C, 4'hF, 32'h1);
        s_clr = 4'h0;
        check("R10", "set beats clear", {28'h0, s_irq}, 32'hC);
        check("R1", "machine set hart3", {28'h0, m_irq}, 32'hC);

        // R8: supervisor read of a pending hart is zero
        access(1'b0, 8'h08, 4'hF, 32'h0);
        check("R8", "supervisor read pending", s_rdata, 32'h0);
        check("R7", "machine read pending", m_rdata, 32'h1);

        // R9: reset clears machine, keeps supervisor
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "machine cleared by reset", {28'h0, m_irq}, 32'h0);
        check("R9", "supervisor kept over reset", {28'h0, s_irq}, 32'hC);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "supervisor kept after reset", {28'h0, s_irq}, 32'hC);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule